// File: doc/BRIEF.md
# Paired-Operand Vector Register File

This block stores the vector state of a SIMD datapath: thirty-two registers of a configurable width, 512 bits by default. Operands reach it as single registers or as register pairs that form a double-width vector. Each read port and the write port names the upper and lower register of a pair on its own, so a pair may be given in ascending order (7:6) or in reversed order (6:7). Each half is routed only by its position in the pair and never by its register number.

A scalar side reaches the file one 32-bit word at a time. Up to two insert lanes place a word into a chosen register. An insert takes a 64-bit scalar pair: the data is in the low half and the word position is in the high half. One extract unit reads a single word back. The extract is slow: it reports busy for a fixed number of cycles and then presents the word. An issue group may carry either inserts or one extract, never both. The block enforces this by dropping an extract request that arrives together with an insert.

Top module: `vrf_pair_file`

## Requirements
- R1: After reset, every register reads as all zeros, and `ext_busy` and `ext_valid` are low.
- R2: Each of the two read ports returns the register selected by its `*_hi_sel` on `*_hi_data` and the register selected by `*_lo_sel` on `*_lo_data`, combinationally. The two selects are independent, so a pair read in ascending or reversed order gives each half by position.
- R3: With `wr_en` and `wr_pair` high, the register named by `wr_hi_sel` takes `wr_hi_data` and the register named by `wr_lo_sel` takes `wr_lo_data`. Both update at the same clock edge, whichever register number is larger. Reads during the write cycle return the old contents, and the new contents appear from the next cycle.
- R4: With `wr_en` high and `wr_pair` low, only the register named by `wr_hi_sel` is written. `wr_lo_sel` and `wr_lo_data` have no effect.
- R5: A pair write whose two selects name the same register stores `wr_hi_data` in it.
- R6: An insert on lane k (`ins_en[k]`) replaces word w = `insK_src[35:32]` of register `insK_sel` with `insK_src[31:0]`. Word w occupies bits [32w+31:32w]. Bits [63:36] of the source are ignored, and all other words of the register keep their value.
- R7: Both insert lanes may act in the same cycle. When both hit the same word of the same register, lane 1 wins. Inserts are applied on top of a vector write to the same register in the same cycle.
- R8: An accepted extract returns word `ext_pos[3:0]` of register `ext_sel` as it stood in the request cycle, before that cycle's writes. Bits [31:4] of `ext_pos` are ignored.
- R9: After the acceptance edge, `ext_busy` is high for exactly EXT_LAT cycles. `ext_valid` then pulses for one cycle with `ext_data` holding the word, and `ext_data` keeps that word until the next result.
- R10: An extract request is ignored, and produces no result, when `ext_busy` is high or when any `ins_en` bit is set in the same cycle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_hi_sel | input | 5 | Read port A, upper register number |
| ra_lo_sel | input | 5 | Read port A, lower register number |
| ra_hi_data | output | 512 | Read port A, upper half |
| ra_lo_data | output | 512 | Read port A, lower half |
| rb_hi_sel | input | 5 | Read port B, upper register number |
| rb_lo_sel | input | 5 | Read port B, lower register number |
| rb_hi_data | output | 512 | Read port B, upper half |
| rb_lo_data | output | 512 | Read port B, lower half |
| wr_en | input | 1 | Vector write enable |
| wr_pair | input | 1 | 1: pair write, 0: single write to the upper select |
| wr_hi_sel | input | 5 | Write, upper register number |
| wr_lo_sel | input | 5 | Write, lower register number |
| wr_hi_data | input | 512 | Write data, upper half |
| wr_lo_data | input | 512 | Write data, lower half |
| ins_en | input | 2 | Insert lane enables |
| ins0_sel | input | 5 | Insert lane 0 target register |
| ins0_src | input | 64 | Insert lane 0 scalar pair (position in high half, data in low half) |
| ins1_sel | input | 5 | Insert lane 1 target register |
| ins1_src | input | 64 | Insert lane 1 scalar pair |
| ext_req | input | 1 | Extract request |
| ext_sel | input | 5 | Extract source register |
| ext_pos | input | 32 | Extract word position (low 4 bits used) |
| ext_busy | output | 1 | Extract in progress |
| ext_valid | output | 1 | One-cycle extract result strobe |
| ext_data | output | 32 | Extract result word |

## Verification
Pair writes are driven in ascending, reversed and equal-number order. Each register of the pair is read back through both read ports, and the write cycle is read as well, so that a swapped half, a missing second write or a write-through shows up. Two pairs, 3:2 and 4:5, are read together and added word by word, which tells routing by position apart from routing by register number. Insert patterns put junk in the unused position bits and use distinct words, the same word on both lanes, and an insert that lands on a vector write. Extract patterns include junk position bits, a write to the source register in the request cycle, and requests made while busy or together with an insert.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int WORD_W   = 32;
  localparam int SCALAR_W = 64;

  typedef enum logic [1:0] {
    EXT_IDLE = 2'd0,
    EXT_WAIT = 2'd1,
    EXT_DONE = 2'd2
  } ext_state_e;
endpackage

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int NUM_REGS = 32,
  parameter int VLEN     = 512,
  localparam int RAW     = $clog2(NUM_REGS),
  localparam int NWORDS  = VLEN / vrf_pkg::WORD_W,
  localparam int IDXW    = $clog2(NWORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_pair,
  input  logic [RAW-1:0]           wr_hi_sel,
  input  logic [RAW-1:0]           wr_lo_sel,
  input  logic [VLEN-1:0]          wr_hi_data,
  input  logic [VLEN-1:0]          wr_lo_data,
  input  logic [1:0]               ins_en,
  input  logic [RAW-1:0]           ins0_sel,
  input  logic [IDXW-1:0]          ins0_idx,
  input  logic [31:0]              ins0_word,
  input  logic [RAW-1:0]           ins1_sel,
  input  logic [IDXW-1:0]          ins1_idx,
  input  logic [31:0]              ins1_word,
  output logic [NUM_REGS*VLEN-1:0] file_q
);
  function automatic logic [VLEN-1:0] put_word(input logic [VLEN-1:0] v,
                                               input logic [IDXW-1:0] i,
                                               input logic [31:0] d);
    logic [VLEN-1:0] r;
    r = v;
    r[i*vrf_pkg::WORD_W +: vrf_pkg::WORD_W] = d;
    return r;
  endfunction

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic            hi_hit, lo_hit, i0_hit, i1_hit;
    logic [VLEN-1:0] nxt, q_r;

    assign hi_hit = wr_en && (wr_hi_sel == RAW'(r));
    assign lo_hit = wr_en && wr_pair && (wr_lo_sel == RAW'(r));
    assign i0_hit = ins_en[0] && (ins0_sel == RAW'(r));
    assign i1_hit = ins_en[1] && (ins1_sel == RAW'(r));

    always_comb begin
      nxt = q_r;
      if (lo_hit) nxt = wr_lo_data;
      if (hi_hit) nxt = wr_hi_data;
      if (i0_hit) nxt = put_word(nxt, ins0_idx, ins0_word);
      if (i1_hit) nxt = put_word(nxt, ins1_idx, ins1_word);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= nxt;
    end

    assign file_q[r*VLEN +: VLEN] = q_r;
  end
endmodule

// File: rtl/vrf_read_port.sv
module vrf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int VLEN     = 512,
  localparam int RAW     = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*VLEN-1:0] file_q,
  input  logic [RAW-1:0]           hi_sel,
  input  logic [RAW-1:0]           lo_sel,
  output logic [VLEN-1:0]          hi_data,
  output logic [VLEN-1:0]          lo_data
);
  function automatic logic [VLEN-1:0] pick(input logic [NUM_REGS*VLEN-1:0] f,
                                           input logic [RAW-1:0] s);
    return f[s*VLEN +: VLEN];
  endfunction

  assign hi_data = pick(file_q, hi_sel);
  assign lo_data = pick(file_q, lo_sel);
endmodule

// File: rtl/vrf_extract.sv
module vrf_extract #(
  parameter int NUM_REGS = 32,
  parameter int VLEN     = 512,
  parameter int EXT_LAT  = 4,
  localparam int RAW     = $clog2(NUM_REGS),
  localparam int NWORDS  = VLEN / vrf_pkg::WORD_W,
  localparam int IDXW    = $clog2(NWORDS),
  localparam int CW      = $clog2(EXT_LAT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REGS*VLEN-1:0] file_q,
  input  logic                     req,
  input  logic                     ins_pending,
  input  logic [RAW-1:0]           sel,
  input  logic [IDXW-1:0]          idx,
  output logic                     accept,
  output logic                     busy,
  output logic                     valid,
  output logic [31:0]              data
);
  import vrf_pkg::*;

  function automatic logic [31:0] get_word(input logic [NUM_REGS*VLEN-1:0] f,
                                           input logic [RAW-1:0] s,
                                           input logic [IDXW-1:0] i);
    logic [VLEN-1:0] v;
    v = f[s*VLEN +: VLEN];
    return v[i*WORD_W +: WORD_W];
  endfunction

  ext_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   snap_q, out_q;

  assign busy   = (state_q == EXT_WAIT);
  assign valid  = (state_q == EXT_DONE);
  assign accept = req && !busy && !ins_pending;
  assign data   = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EXT_IDLE;
      cnt_q   <= '0;
      snap_q  <= '0;
      out_q   <= '0;
    end else begin
      case (state_q)
        EXT_WAIT: begin
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            state_q <= EXT_DONE;
            out_q   <= snap_q;
          end
        end
        default: begin
          if (accept) begin
            state_q <= EXT_WAIT;
            cnt_q   <= CW'(EXT_LAT);
            snap_q  <= get_word(file_q, sel, idx);
          end else begin
            state_q <= EXT_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vrf_pair_file.sv
module vrf_pair_file #(
  parameter int NUM_REGS = 32,
  parameter int VLEN     = 512,
  parameter int EXT_LAT  = 4,
  localparam int RAW     = $clog2(NUM_REGS),
  localparam int NWORDS  = VLEN / vrf_pkg::WORD_W,
  localparam int IDXW    = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW-1:0]   ra_hi_sel,
  input  logic [RAW-1:0]   ra_lo_sel,
  output logic [VLEN-1:0]  ra_hi_data,
  output logic [VLEN-1:0]  ra_lo_data,
  input  logic [RAW-1:0]   rb_hi_sel,
  input  logic [RAW-1:0]   rb_lo_sel,
  output logic [VLEN-1:0]  rb_hi_data,
  output logic [VLEN-1:0]  rb_lo_data,
  input  logic             wr_en,
  input  logic             wr_pair,
  input  logic [RAW-1:0]   wr_hi_sel,
  input  logic [RAW-1:0]   wr_lo_sel,
  input  logic [VLEN-1:0]  wr_hi_data,
  input  logic [VLEN-1:0]  wr_lo_data,
  input  logic [1:0]       ins_en,
  input  logic [RAW-1:0]   ins0_sel,
  input  logic [63:0]      ins0_src,
  input  logic [RAW-1:0]   ins1_sel,
  input  logic [63:0]      ins1_src,
  input  logic             ext_req,
  input  logic [RAW-1:0]   ext_sel,
  input  logic [31:0]      ext_pos,
  output logic             ext_busy,
  output logic             ext_valid,
  output logic [31:0]      ext_data
);
  // word position from a 32-bit scalar: keep only the bits that address a word
  function automatic logic [IDXW-1:0] word_pos(input logic [31:0] s);
    return IDXW'(s & 32'(NWORDS - 1));
  endfunction

  logic [NUM_REGS*VLEN-1:0] file_q;
  logic [IDXW-1:0]          ins0_idx, ins1_idx, ext_idx;
  logic                     ins_pending;
  logic                     ext_accept;

  assign ins0_idx    = word_pos(ins0_src[63:32]);
  assign ins1_idx    = word_pos(ins1_src[63:32]);
  assign ext_idx     = word_pos(ext_pos);
  assign ins_pending = |ins_en;

  vrf_bank #(.NUM_REGS(NUM_REGS), .VLEN(VLEN)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_pair(wr_pair),
    .wr_hi_sel(wr_hi_sel), .wr_lo_sel(wr_lo_sel),
    .wr_hi_data(wr_hi_data), .wr_lo_data(wr_lo_data),
    .ins_en(ins_en),
    .ins0_sel(ins0_sel), .ins0_idx(ins0_idx), .ins0_word(ins0_src[31:0]),
    .ins1_sel(ins1_sel), .ins1_idx(ins1_idx), .ins1_word(ins1_src[31:0]),
    .file_q(file_q)
  );

  vrf_read_port #(.NUM_REGS(NUM_REGS), .VLEN(VLEN)) rda_i (
    .file_q(file_q), .hi_sel(ra_hi_sel), .lo_sel(ra_lo_sel),
    .hi_data(ra_hi_data), .lo_data(ra_lo_data)
  );

  vrf_read_port #(.NUM_REGS(NUM_REGS), .VLEN(VLEN)) rdb_i (
    .file_q(file_q), .hi_sel(rb_hi_sel), .lo_sel(rb_lo_sel),
    .hi_data(rb_hi_data), .lo_data(rb_lo_data)
  );

  vrf_extract #(.NUM_REGS(NUM_REGS), .VLEN(VLEN), .EXT_LAT(EXT_LAT)) ext_i (
    .clk(clk), .rst_n(rst_n), .file_q(file_q),
    .req(ext_req), .ins_pending(ins_pending),
    .sel(ext_sel), .idx(ext_idx),
    .accept(ext_accept), .busy(ext_busy), .valid(ext_valid), .data(ext_data)
  );
endmodule

// File: rtl/vrf_pair_file_chk.sv
module vrf_pair_file_chk #(
  parameter int RAW     = 5,
  parameter int VLEN    = 512,
  parameter int EXT_LAT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_pair,
  input logic [RAW-1:0]  wr_hi_sel,
  input logic [RAW-1:0]  wr_lo_sel,
  input logic [VLEN-1:0] wr_hi_data,
  input logic [VLEN-1:0] wr_lo_data,
  input logic [1:0]      ins_en,
  input logic [RAW-1:0]  ra_hi_sel,
  input logic [RAW-1:0]  ra_lo_sel,
  input logic [VLEN-1:0] ra_hi_data,
  input logic [VLEN-1:0] ra_lo_data,
  input logic            ext_req,
  input logic            ext_accept,
  input logic            ext_busy,
  input logic            ext_valid
);
  logic [31:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        busy_run <= '0;
    else if (ext_busy) busy_run <= busy_run + 32'd1;
    else               busy_run <= '0;
  end

  // R2
  same_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_hi_sel == ra_lo_sel) |-> (ra_hi_data == ra_lo_data));

  // R3
  pair_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pair && wr_hi_sel != wr_lo_sel && ins_en == 2'b00)
    |=> ((ra_lo_sel == $past(wr_lo_sel)) -> (ra_lo_data == $past(wr_lo_data))));

  // R5
  pair_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ins_en == 2'b00)
    |=> ((ra_hi_sel == $past(wr_hi_sel)) -> (ra_hi_data == $past(wr_hi_data))));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_accept |=> ext_busy);

  // R9
  valid_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> !ext_busy);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |=> !ext_valid);

  // R9
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (busy_run == 32'(EXT_LAT)));

  // R10
  req_with_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ins_en != 2'b00 && !ext_busy) |=> !ext_busy);
endmodule

bind vrf_pair_file vrf_pair_file_chk #(.RAW(RAW), .VLEN(VLEN), .EXT_LAT(EXT_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .wr_en(wr_en), .wr_pair(wr_pair),
  .wr_hi_sel(wr_hi_sel), .wr_lo_sel(wr_lo_sel),
  .wr_hi_data(wr_hi_data), .wr_lo_data(wr_lo_data),
  .ins_en(ins_en),
  .ra_hi_sel(ra_hi_sel), .ra_lo_sel(ra_lo_sel),
  .ra_hi_data(ra_hi_data), .ra_lo_data(ra_lo_data),
  .ext_req(ext_req), .ext_accept(ext_accept),
  .ext_busy(ext_busy), .ext_valid(ext_valid)
);

// File: tb/vrf_pair_file_tb_top.sv
module vrf_pair_file_tb_top;
  localparam int VLEN = 512;
  localparam int LAT  = 4;
  localparam int NW   = VLEN / 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      ra_hi_sel = '0, ra_lo_sel = '0, rb_hi_sel = '0, rb_lo_sel = '0;
  logic [VLEN-1:0] ra_hi_data, ra_lo_data, rb_hi_data, rb_lo_data;
  logic            wr_en = 1'b0, wr_pair = 1'b0;
  logic [4:0]      wr_hi_sel = '0, wr_lo_sel = '0;
  logic [VLEN-1:0] wr_hi_data = '0, wr_lo_data = '0;
  logic [1:0]      ins_en = '0;
  logic [4:0]      ins0_sel = '0, ins1_sel = '0;
  logic [63:0]     ins0_src = '0, ins1_src = '0;
  logic            ext_req = 1'b0;
  logic [4:0]      ext_sel = '0;
  logic [31:0]     ext_pos = '0;
  logic            ext_busy, ext_valid;
  logic [31:0]     ext_data;

  always #10 clk = ~clk;

  vrf_pair_file #(.VLEN(VLEN), .EXT_LAT(LAT)) dut_i (.*);

  int n_chk = 0, n_fail = 0, n_valid = 0, busy_cnt = 0;
  logic [VLEN-1:0] mdl [32];
  logic [31:0] expq [$];
  bit done = 1'b0;

  function automatic logic [VLEN-1:0] pat(input int seed);
    logic [VLEN-1:0] v;
    for (int w = 0; w < NW; w++)
      v[w*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(w) * 32'h01000193 + 32'h5A5A0000;
    return v;
  endfunction

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int r);
    ra_hi_sel = 5'(r); rb_lo_sel = 5'(r);
    #1;
    chk(req, ra_hi_data, mdl[r]);
    chk(req, rb_lo_data, mdl[r]);
  endtask

  task automatic vwrite(input bit pair, input int hi, input int lo,
                        input logic [VLEN-1:0] hd, input logic [VLEN-1:0] ld, input string req);
    wr_en = 1'b1; wr_pair = pair; wr_hi_sel = 5'(hi); wr_lo_sel = 5'(lo);
    wr_hi_data = hd; wr_lo_data = ld;
    ra_hi_sel = 5'(hi); ra_lo_sel = 5'(lo);
    #1;
    chk({req, " old value in write cycle"}, ra_hi_data, mdl[hi]);
    chk({req, " old value in write cycle"}, ra_lo_data, mdl[lo]);
    @(negedge clk);
    wr_en = 1'b0;
    if (pair) mdl[lo] = ld;
    mdl[hi] = hd;
  endtask

  // monitor: scoreboard for extract results
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ext_valid) begin
        n_valid++;
        n_chk++;
        if (busy_cnt != LAT) begin
          n_fail++;
          $display("FAIL R9 busy cycles act=%0d exp=%0d", busy_cnt, LAT);
        end
        if (expq.size() == 0) begin
          n_fail++; n_chk++;
          $display("FAIL R10 unexpected extract result act=%h exp=none", ext_data);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          n_chk++;
          if (ext_data !== e) begin
            n_fail++;
            $display("FAIL R8 extract data act=%h exp=%h", ext_data, e);
          end
        end
        busy_cnt = 0;
      end else if (ext_busy) busy_cnt++;
      else busy_cnt = 0;
    end
  end

  task automatic extract(input int r, input logic [31:0] pos, input bit expect_accept);
    ext_req = 1'b1; ext_sel = 5'(r); ext_pos = pos;
    if (expect_accept) expq.push_back(mdl[r][pos[3:0]*32 +: 32]);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] v;
    int nv;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk_reg("R1", 0); chk_reg("R1", 17); chk_reg("R1", 31);
    chk("R1 busy/valid", VLEN'({ext_busy, ext_valid}), '0);

    // R4: single writes, lower select ignored
    for (int i = 0; i < 8; i++) vwrite(1'b0, i, 20, pat(i + 1), pat(99), "R4");
    chk_reg("R4 target", 5);
    chk_reg("R4 lower select untouched", 20);

    // R3: ascending pair 7:6 then reversed pair 12:13
    vwrite(1'b1, 7, 6, pat(70), pat(60), "R3");
    chk_reg("R3 ascending upper", 7); chk_reg("R3 ascending lower", 6);
    vwrite(1'b1, 12, 13, pat(120), pat(130), "R3");
    chk_reg("R3 reversed upper", 12); chk_reg("R3 reversed lower", 13);

    // R5: equal numbers
    vwrite(1'b1, 9, 9, pat(90), pat(91), "R5");
    chk_reg("R5 equal pair", 9);

    // R2: 3:2 plus 4:5, halves routed by position
    ra_hi_sel = 5'd3; ra_lo_sel = 5'd2; rb_hi_sel = 5'd4; rb_lo_sel = 5'd5;
    #1;
    for (int w = 0; w < NW; w++) begin
      v[w*32 +: 32] = ra_hi_data[w*32 +: 32] + rb_hi_data[w*32 +: 32];
    end
    begin
      logic [VLEN-1:0] e;
      for (int w = 0; w < NW; w++) e[w*32 +: 32] = mdl[3][w*32 +: 32] + mdl[4][w*32 +: 32];
      chk("R2 upper sum V3+V4", v, e);
      for (int w = 0; w < NW; w++) begin
        v[w*32 +: 32] = ra_lo_data[w*32 +: 32] + rb_lo_data[w*32 +: 32];
        e[w*32 +: 32] = mdl[2][w*32 +: 32] + mdl[5][w*32 +: 32];
      end
      chk("R2 lower sum V2+V5", v, e);
    end
    chk("R2 reversed read lo", rb_lo_data, mdl[5]);

    // R6: insert with junk position bits, word 5
    ins_en = 2'b01; ins0_sel = 5'd10; ins0_src = {32'hABCDE5F5, 32'hCAFE0001};
    @(negedge clk); ins_en = 2'b00;
    mdl[10][5*32 +: 32] = 32'hCAFE0001;
    chk_reg("R6 insert word 5", 10);

    // R7: both lanes, distinct words then same word
    ins_en = 2'b11; ins0_sel = 5'd11; ins0_src = {32'd0, 32'h11111111};
    ins1_sel = 5'd11; ins1_src = {32'd15, 32'h22222222};
    @(negedge clk); ins_en = 2'b00;
    mdl[11][0 +: 32] = 32'h11111111; mdl[11][15*32 +: 32] = 32'h22222222;
    chk_reg("R7 two lanes", 11);
    ins_en = 2'b11; ins0_src = {32'd3, 32'hAAAA0000}; ins1_src = {32'h13, 32'hBBBB0000};
    @(negedge clk); ins_en = 2'b00;
    mdl[11][3*32 +: 32] = 32'hBBBB0000;
    chk_reg("R7 lane1 wins", 11);
    // R7: insert over same-cycle vector write
    ins_en = 2'b01; ins0_sel = 5'd14; ins0_src = {32'd7, 32'h0DDBA11};
    vwrite(1'b0, 14, 0, pat(140), '0, "R7");
    ins_en = 2'b00;
    mdl[14][7*32 +: 32] = 32'h0DDBA11;
    chk_reg("R7 insert over write", 14);

    // R8/R9: extract with junk position bits, concurrent write to source
    extract(7, 32'hFFFFFFF2, 1'b1);
    wr_en = 1'b1; wr_pair = 1'b0; wr_hi_sel = 5'd7; wr_hi_data = pat(777);
    @(negedge clk);
    ext_req = 1'b0; wr_en = 1'b0; mdl[7] = pat(777);
    // R10: request while busy is ignored
    nv = n_valid;
    extract(12, 32'd1, 1'b0);
    @(negedge clk); ext_req = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    n_chk++;
    if (n_valid != nv + 1) begin
      n_fail++; $display("FAIL R10 results after busy request act=%0d exp=%0d", n_valid - nv, 1);
    end
    // R9: data held after strobe
    chk("R9 data held", VLEN'(ext_data), VLEN'(pat(70)[2*32 +: 32]));

    // R10: request alongside insert is dropped
    extract(13, 32'd4, 1'b0);
    ins_en = 2'b10; ins1_sel = 5'd20; ins1_src = {32'd2, 32'h77777777};
    @(negedge clk);
    ext_req = 1'b0; ins_en = 2'b00; mdl[20][2*32 +: 32] = 32'h77777777;
    chk("R10 no busy after insert-collided request", VLEN'(ext_busy), '0);
    repeat (LAT + 3) @(negedge clk);

    // R8: second extract, last word
    extract(13, 32'd15, 1'b1);
    @(negedge clk); ext_req = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    n_chk++;
    if (expq.size() != 0) begin
      n_fail++; $display("FAIL R8 pending results act=%0d exp=0", expq.size());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule